// File: doc/BRIEF.md
# Doorbell Mailbox Device Register File

This block is the device-side register set of a command mailbox. A host reaches it over a simple word-addressed register bus. Through that bus the host sees a capability word, a control word with a doorbell bit, a 64-bit command register, a return-code register, a live device health word and a RAM window that holds the payload. The host fills in the command and the payload, then rings the doorbell. From that moment the device owns the command, the payload and the status.

On the local side, a responder sees a one-cycle command pulse together with the opcode and the input length. While the doorbell is set, the responder can read and write the payload RAM. It finishes by presenting a completion with a return code and an output length. The block loads both values at once and drops the doorbell one cycle later. Once the doorbell is clear, nothing the responder does can alter the command, the status or the payload until the host rings again. Command execution itself happens outside this block.

Top module: `mbx_regfile`

## Requirements
- R1: After reset the doorbell reads 0, the command words read 0, the return code reads 0 and no command pulse is present.
- R2: Word 0 reads the payload size exponent PAY_EXP in bits [4:0]. PAY_EXP must lie between 8 and 20, which gives 256 B to 1 MiB. The payload window spans 2^PAY_EXP bytes, starting at word address 2^(PAY_EXP-2).
- R3: Word 2 holds the opcode in bits [15:0] and length bits [15:0] in bits [31:16]. Word 3 holds length bits [20:16] in bits [4:0]. The same 21-bit length field carries the input length written by the host and the output length written by the responder.
- R4: A host write to word 1 with bit 0 set, made while the doorbell is clear, sets the doorbell. The doorbell then reads 1 until completion. rsp_cmd_pulse is high for exactly the one cycle after that write, with the opcode and input length valid on the responder side. A write of 0 has no effect, and a second ring while the doorbell is set gives no pulse.
- R5: rsp_cpl sampled while the doorbell is set loads the return code and output length, which are readable in the next cycle. The doorbell clears one cycle after that. rsp_cpl while the doorbell is clear is ignored.
- R6: Word 4 reads the return code in bits [15:0]; the value 0 means success.
- R7: Word 5 reflects the device health inputs: bit 0 interface ready, bit 1 device ready, bit 2 fatal, bit 3 firmware halted, bits [5:4] reset-needed.
- R8: While the doorbell is set, host writes to words 2 and 3 and to the payload window are ignored, and hst_wr_err is high for the one cycle after each such write.
- R9: After the doorbell clears, the command, return code and payload do not change through the responder side until the next ring. Responder payload writes in the cycle after a completion are already ignored.
- R10: While the doorbell is clear the host reads and writes the payload window. While the doorbell is set the responder does. Host reads of unmapped register words, or of addresses above the window, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_addr | input | PAY_EXP | Host word address |
| hst_wr | input | 1 | Host write strobe |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data for hst_addr (combinational) |
| hst_wr_err | output | 1 | Pulse: host write refused because the doorbell was set |
| dev_if_ready | input | 1 | Mailbox interface ready |
| dev_ready | input | 1 | Device ready |
| dev_fatal | input | 1 | Device fatal error |
| dev_fw_halt | input | 1 | Firmware halted |
| dev_rst_need | input | 2 | Reset-needed code |
| rsp_busy | output | 1 | Doorbell state |
| rsp_cmd_pulse | output | 1 | One-cycle new-command indication |
| rsp_opcode | output | 16 | Current opcode |
| rsp_in_len | output | 21 | Current length field |
| rsp_pl_addr | input | PAY_EXP-2 | Responder payload word index |
| rsp_pl_rdata | output | 32 | Responder payload read data |
| rsp_pl_wr | input | 1 | Responder payload write strobe |
| rsp_pl_wdata | input | 32 | Responder payload write data |
| rsp_cpl | input | 1 | Completion strobe |
| rsp_ret_code | input | 16 | Completion return code |
| rsp_out_len | input | 21 | Completion output length |

## Verification
Four full transactions exercise the main function, with different opcodes, payload words and lengths. They pair a zero return code with non-zero ones, and include lengths whose upper five bits are set. This shows that the two command words are combined correctly and that the length field switches from input to output use. Directed cases then try a ring while busy, a write of 0 to the doorbell and host writes to the command and payload while busy. They also try completions and payload writes from the responder when it no longer owns the mailbox, including the single cycle between completion and doorbell clear. In every case the state is read back through the host port to tell a refused access from an accepted one.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int OPC_W = 16;
    localparam int LEN_W = 21;
    localparam int RET_W = 16;
    localparam int DAT_W = 32;

    localparam logic [2:0] IDX_CAPS   = 3'd0;
    localparam logic [2:0] IDX_CTRL   = 3'd1;
    localparam logic [2:0] IDX_CMD_LO = 3'd2;
    localparam logic [2:0] IDX_CMD_HI = 3'd3;
    localparam logic [2:0] IDX_STAT   = 3'd4;
    localparam logic [2:0] IDX_DEVST  = 3'd5;

    typedef struct packed {
        logic caps;
        logic ctrl;
        logic cmd_lo;
        logic cmd_hi;
        logic stat;
        logic devst;
        logic win;
    } mbx_sel_t;

    typedef struct packed {
        logic             busy;
        logic             clr_pend;
        logic             pulse;
        logic             err;
        logic [OPC_W-1:0] opc;
        logic [LEN_W-1:0] len;
        logic [RET_W-1:0] ret;
    } mbx_state_t;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic [AW-1:0] addr,
    output mbx_sel_t      sel
);
    logic in_regs;

    always_comb begin
        in_regs    = (addr[AW-1:3] == '0);
        sel        = '0;
        sel.caps   = in_regs && (addr[2:0] == IDX_CAPS);
        sel.ctrl   = in_regs && (addr[2:0] == IDX_CTRL);
        sel.cmd_lo = in_regs && (addr[2:0] == IDX_CMD_LO);
        sel.cmd_hi = in_regs && (addr[2:0] == IDX_CMD_HI);
        sel.stat   = in_regs && (addr[2:0] == IDX_STAT);
        sel.devst  = in_regs && (addr[2:0] == IDX_DEVST);
        sel.win    = (addr[AW-1 -: 2] == 2'b01);
    end
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
    import mbx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hwr,
    input  mbx_sel_t         sel,
    input  logic [DAT_W-1:0] wdata,
    input  logic             cpl,
    input  logic [RET_W-1:0] cpl_ret,
    input  logic [LEN_W-1:0] cpl_len,
    output mbx_state_t       st_q
);
    mbx_state_t st_d;

    always_comb begin
        st_d          = st_q;
        st_d.pulse    = 1'b0;
        st_d.err      = 1'b0;
        st_d.clr_pend = 1'b0;
        if (st_q.busy) begin
            // device owns the mailbox: host edits are refused
            if (hwr && (sel.cmd_lo || sel.cmd_hi || sel.win))
                st_d.err = 1'b1;
            if (st_q.clr_pend) begin
                st_d.busy = 1'b0;
            end else if (cpl) begin
                st_d.ret      = cpl_ret;
                st_d.len      = cpl_len;
                st_d.clr_pend = 1'b1;
            end
        end else if (hwr) begin
            if (sel.cmd_lo) begin
                st_d.opc        = wdata[OPC_W-1:0];
                st_d.len[15:0]  = wdata[31:16];
            end
            if (sel.cmd_hi)
                st_d.len[LEN_W-1:16] = wdata[LEN_W-17:0];
            if (sel.ctrl && wdata[0]) begin
                st_d.busy  = 1'b1;
                st_d.pulse = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/mbx_payload_ram.sv
module mbx_payload_ram #(
    parameter int IW = 6,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [IW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    localparam int DEPTH = 1 << IW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/mbx_regfile.sv
module mbx_regfile
    import mbx_pkg::*;
#(
    parameter int PAY_EXP = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PAY_EXP-1:0] hst_addr,
    input  logic               hst_wr,
    input  logic [31:0]        hst_wdata,
    output logic [31:0]        hst_rdata,
    output logic               hst_wr_err,
    input  logic               dev_if_ready,
    input  logic               dev_ready,
    input  logic               dev_fatal,
    input  logic               dev_fw_halt,
    input  logic [1:0]         dev_rst_need,
    output logic               rsp_busy,
    output logic               rsp_cmd_pulse,
    output logic [15:0]        rsp_opcode,
    output logic [20:0]        rsp_in_len,
    input  logic [PAY_EXP-3:0] rsp_pl_addr,
    output logic [31:0]        rsp_pl_rdata,
    input  logic               rsp_pl_wr,
    input  logic [31:0]        rsp_pl_wdata,
    input  logic               rsp_cpl,
    input  logic [15:0]        rsp_ret_code,
    input  logic [20:0]        rsp_out_len
);
    localparam int AW = PAY_EXP;
    localparam int IW = PAY_EXP - 2;

    mbx_sel_t      sel;
    mbx_state_t    st_q;
    logic          ram_we;
    logic [IW-1:0] ram_waddr;
    logic [31:0]   ram_wdata;
    logic [31:0]   host_ram_rdata;

    mbx_decode #(.AW(AW)) u_dec (
        .addr (hst_addr),
        .sel  (sel)
    );

    mbx_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .hwr     (hst_wr),
        .sel     (sel),
        .wdata   (hst_wdata),
        .cpl     (rsp_cpl),
        .cpl_ret (rsp_ret_code),
        .cpl_len (rsp_out_len),
        .st_q    (st_q)
    );

    // ownership picks the single writer of the payload RAM
    always_comb begin
        if (st_q.busy) begin
            ram_we    = rsp_pl_wr && !st_q.clr_pend;
            ram_waddr = rsp_pl_addr;
            ram_wdata = rsp_pl_wdata;
        end else begin
            ram_we    = hst_wr && sel.win;
            ram_waddr = hst_addr[IW-1:0];
            ram_wdata = hst_wdata;
        end
    end

    mbx_payload_ram #(.IW(IW), .DW(32)) u_ram (
        .clk     (clk),
        .we      (ram_we),
        .waddr   (ram_waddr),
        .wdata   (ram_wdata),
        .raddr_a (hst_addr[IW-1:0]),
        .rdata_a (host_ram_rdata),
        .raddr_b (rsp_pl_addr),
        .rdata_b (rsp_pl_rdata)
    );

    always_comb begin
        hst_rdata = '0;
        unique case (1'b1)
            sel.caps:   hst_rdata[4:0]  = 5'(PAY_EXP);
            sel.ctrl:   hst_rdata[0]    = st_q.busy;
            sel.cmd_lo: hst_rdata       = {st_q.len[15:0], st_q.opc};
            sel.cmd_hi: hst_rdata[4:0]  = st_q.len[20:16];
            sel.stat:   hst_rdata[15:0] = st_q.ret;
            sel.devst:  hst_rdata[5:0]  = {dev_rst_need, dev_fw_halt, dev_fatal,
                                           dev_ready, dev_if_ready};
            sel.win:    hst_rdata       = host_ram_rdata;
            default:    hst_rdata       = '0;
        endcase
    end

    assign hst_wr_err    = st_q.err;
    assign rsp_busy      = st_q.busy;
    assign rsp_cmd_pulse = st_q.pulse;
    assign rsp_opcode    = st_q.opc;
    assign rsp_in_len    = st_q.len;
endmodule

// File: rtl/mbx_regfile_chk.sv
module mbx_regfile_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        pulse,
    input logic        cpl,
    input logic        err,
    input logic [15:0] ret
);
    assert_pulse_on_ring_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> pulse);

    assert_pulse_only_new_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> (busy && !$past(busy)));

    assert_clear_after_cpl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(cpl, 2));

    assert_err_only_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(busy));

    assert_ret_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> $stable(ret));
endmodule

bind mbx_regfile mbx_regfile_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (rsp_busy),
    .pulse (rsp_cmd_pulse),
    .cpl   (rsp_cpl),
    .err   (hst_wr_err),
    .ret   (st_q.ret)
);

// File: tb/mbx_regfile_bench.sv
`timescale 1ns/1ps
module mbx_regfile_bench;
    localparam int PE   = 8;
    localparam int WBASE = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PE-1:0] hst_addr = '0;
    logic          hst_wr = 1'b0;
    logic [31:0]   hst_wdata = '0;
    logic [31:0]   hst_rdata;
    logic          hst_wr_err;
    logic          dev_if_ready = 1'b0, dev_ready = 1'b0, dev_fatal = 1'b0, dev_fw_halt = 1'b0;
    logic [1:0]    dev_rst_need = 2'b00;
    logic          rsp_busy, rsp_cmd_pulse;
    logic [15:0]   rsp_opcode;
    logic [20:0]   rsp_in_len;
    logic [PE-3:0] rsp_pl_addr = '0;
    logic [31:0]   rsp_pl_rdata;
    logic          rsp_pl_wr = 1'b0;
    logic [31:0]   rsp_pl_wdata = '0;
    logic          rsp_cpl = 1'b0;
    logic [15:0]   rsp_ret_code = '0;
    logic [20:0]   rsp_out_len = '0;

    int checks = 0;
    int errors = 0;
    logic got_pulse, got_err;
    logic [31:0] rd;

    always #2.5 clk = ~clk;

    mbx_regfile #(.PAY_EXP(PE)) u_mbx_regfile (.*);

    typedef struct packed {
        logic [15:0] opc;
        logic [20:0] in_len;
        logic [15:0] ret;
        logic [20:0] out_len;
        logic [5:0]  idx;
        logic [31:0] pl_in;
        logic [31:0] pl_out;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{16'h0001, 21'h000010, 16'h0000, 21'h000040, 6'd0,  32'hA5A5_0001, 32'h1234_5678},
        '{16'h4300, 21'h1F0100, 16'h0005, 21'h100003, 6'd9,  32'hDEAD_BEEF, 32'h0BAD_F00D},
        '{16'hFFFF, 21'h00FFFF, 16'h0000, 21'h1FFFFF, 6'd63, 32'h0000_0000, 32'hFFFF_FFFF},
        '{16'h8001, 21'h010000, 16'hC00C, 21'h000000, 6'd31, 32'h5555_AAAA, 32'h7777_1111}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic host_write(input int a, input logic [31:0] d);
        @(negedge clk);
        hst_addr = PE'(a); hst_wdata = d; hst_wr = 1'b1;
        @(negedge clk);
        got_pulse = rsp_cmd_pulse; got_err = hst_wr_err;
        hst_wr = 1'b0;
    endtask

    task automatic host_read(input int a, output logic [31:0] d);
        @(negedge clk);
        hst_addr = PE'(a);
        #1 d = hst_rdata;
    endtask

    task automatic resp_write(input logic [5:0] i, input logic [31:0] d);
        @(negedge clk);
        rsp_pl_addr = i; rsp_pl_wdata = d; rsp_pl_wr = 1'b1;
        @(negedge clk);
        rsp_pl_wr = 1'b0;
    endtask

    // completion; checks the two-step timing
    task automatic complete(input logic [15:0] r, input logic [20:0] l, input logic tchk);
        @(negedge clk);
        rsp_cpl = 1'b1; rsp_ret_code = r; rsp_out_len = l;
        @(negedge clk);
        rsp_cpl = 1'b0;
        if (tchk) begin
            check("R5 busy held in load cycle", 32'(rsp_busy), 32'd1);
            hst_addr = PE'(4);
            #1 check("R5 ret loaded after one cycle", hst_rdata, {16'h0, r});
        end
        @(negedge clk);
        if (tchk) check("R5 busy cleared next cycle", 32'(rsp_busy), 32'd0);
    endtask

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1, R2 reset state
        check("R1 pulse at reset", 32'(rsp_cmd_pulse), 32'd0);
        host_read(0, rd); check("R2 caps exponent", rd, 32'd8);
        host_read(1, rd); check("R1 doorbell at reset", rd, 32'd0);
        host_read(2, rd); check("R1 cmd lo at reset", rd, 32'd0);
        host_read(3, rd); check("R1 cmd hi at reset", rd, 32'd0);
        host_read(4, rd); check("R1 status at reset", rd, 32'd0);

        // R7 device status
        dev_if_ready = 1; dev_ready = 0; dev_fatal = 1; dev_fw_halt = 0; dev_rst_need = 2'b10;
        host_read(5, rd); check("R7 health bits", rd, 32'h25);
        dev_if_ready = 0; dev_ready = 1; dev_fatal = 0; dev_fw_halt = 1; dev_rst_need = 2'b01;
        host_read(5, rd); check("R7 health bits", rd, 32'h1A);

        // R4 write of zero does not ring
        host_write(1, 32'h0);
        check("R4 zero write no pulse", 32'(got_pulse), 32'd0);
        host_read(1, rd); check("R4 zero write no doorbell", rd, 32'd0);

        // main table
        for (int v = 0; v < 4; v++) begin
            host_write(2, {VEC[v].in_len[15:0], VEC[v].opc});
            check("R8 no err when idle", 32'(got_err), 32'd0);
            host_write(3, {27'h0, VEC[v].in_len[20:16]});
            host_write(WBASE + int'(VEC[v].idx), VEC[v].pl_in);
            host_read(2, rd); check("R3 cmd lo layout", rd, {VEC[v].in_len[15:0], VEC[v].opc});
            host_read(3, rd); check("R3 cmd hi layout", rd, {27'h0, VEC[v].in_len[20:16]});
            host_write(1, 32'h1);
            check("R4 pulse after ring", 32'(got_pulse), 32'd1);
            check("R4 opcode to responder", 32'(rsp_opcode), 32'(VEC[v].opc));
            check("R4 in len to responder", 32'(rsp_in_len), 32'(VEC[v].in_len));
            host_read(1, rd); check("R4 doorbell reads 1", rd, 32'd1);
            check("R4 pulse one cycle", 32'(rsp_cmd_pulse), 32'd0);
            @(negedge clk);
            rsp_pl_addr = VEC[v].idx;
            #1 check("R10 responder reads payload", rsp_pl_rdata, VEC[v].pl_in);
            resp_write(VEC[v].idx, VEC[v].pl_out);
            complete(VEC[v].ret, VEC[v].out_len, 1'b1);
            host_read(4, rd); check("R6 return code", rd, {16'h0, VEC[v].ret});
            host_read(2, rd); check("R3 out len lo", rd, {VEC[v].out_len[15:0], VEC[v].opc});
            host_read(3, rd); check("R3 out len hi", rd, {27'h0, VEC[v].out_len[20:16]});
            host_read(WBASE + int'(VEC[v].idx), rd); check("R10 host reads output", rd, VEC[v].pl_out);
        end

        // R10 unmapped and beyond-window reads
        host_read(6, rd); check("R10 unmapped word", rd, 32'd0);
        host_write(200, 32'hFFFF_FFFF);
        host_read(200, rd); check("R10 beyond window", rd, 32'd0);

        // R8 host writes while busy
        host_write(2, 32'h0003_0042);
        host_write(WBASE + 5, 32'h1111_2222);
        host_write(1, 32'h1);
        host_write(2, 32'h9999_9999);
        check("R8 err on cmd write", 32'(got_err), 32'd1);
        host_write(WBASE + 5, 32'h3333_4444);
        check("R8 err on payload write", 32'(got_err), 32'd1);
        host_write(1, 32'h1);
        check("R4 no pulse when re-rung", 32'(got_pulse), 32'd0);
        host_write(1, 32'h0);
        host_read(1, rd); check("R4 doorbell held", rd, 32'd1);
        host_read(2, rd); check("R8 cmd unchanged", rd, 32'h0003_0042);
        host_read(WBASE + 5, rd); check("R8 payload unchanged", rd, 32'h1111_2222);

        // R9 responder write in clear-pending cycle ignored
        @(negedge clk);
        rsp_cpl = 1'b1; rsp_ret_code = 16'h00AB; rsp_out_len = 21'h7;
        @(negedge clk);
        rsp_cpl = 1'b0; rsp_pl_addr = 6'd5; rsp_pl_wdata = 32'hBBBB_0000; rsp_pl_wr = 1'b1;
        @(negedge clk);
        rsp_pl_wr = 1'b0;
        host_read(WBASE + 5, rd); check("R9 late responder write ignored", rd, 32'h1111_2222);

        // R9 responder activity while idle
        complete(16'h0F0F, 21'h1ABCD, 1'b0);
        host_read(4, rd); check("R9 R5 idle completion ignored", rd, 32'h0000_00AB);
        host_read(2, rd); check("R9 cmd frozen", rd, 32'h0007_0042);
        resp_write(6'd5, 32'hCCCC_DDDD);
        host_read(WBASE + 5, rd); check("R9 idle responder write ignored", rd, 32'h1111_2222);
        host_read(1, rd); check("R5 idle completion no doorbell", rd, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule